// File: doc/BRIEF.md
# LCD Blink and Display-Enable Controller

This block decides, frame by frame, what a segment LCD driver shows. Two command strobes load its settings. The first write carries a two-bit blink rate and a blink style. The second carries a display switch and a low-power bit. A fixed-rate tick arrives from the frame timing, and the block divides it down to produce the blink phase. From the settings and the phase it gates the segment word on its way to the waveform generator. It also drives three outputs: a blank flag, a bank-swap override for the display-memory read path, and a divider select for the timing block.

There are two blink styles. In blanking blink, the segments are forced dark for the second half of every blink period. In alternating blink, the segments stay visible. The bank-swap output is raised for the second half of every period, so the data path reads the other memory bank. When the display switch is off, the panel is dark whatever the blink state is.

Top module: `lcd_blink_ctl`

## Requirements
- R1: After reset the rate is off, the style is blanking, the display is switched off and low power is off. So `blank`=1, `seg_out`=0, `bank_swap`=0 and `div_sel`=0.
- R2: While the display switch is 0, `blank`=1 and `seg_out` is all zeros in every blink state and style.
- R3: Rate code 00 means no blinking. With the display on, `seg_out` equals `seg_in`, `blank`=0 and `bank_swap`=0, and ticks change nothing.
- R4: Rate codes 01, 10 and 11 (2 Hz, 1 Hz, 0.5 Hz) give a half period of TICK_HZ/4, TICK_HZ/2 and TICK_HZ ticks. With TICK_HZ=8 these are 2, 4 and 8 ticks.
- R5: In blanking style (style bit 0), `seg_out`=0 and `blank`=1 during the second half of each period. The first half is visible.
- R6: In alternating style (style bit 1), `bank_swap`=1 during the second half of each period and 0 during the first. With the display on, `seg_out` always equals `seg_in`.
- R7: Every blink-config write restarts the divider at zero in the first (visible, unswapped) half, even if a tick arrives in the same cycle.
- R8: The low-power bit (1 = power saving) appears on `div_sel` in the cycle after its write.
- R9: Settings change only on their own write strobe. A display write leaves the blink state alone, and a blink write leaves the display and power bits alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle pulse at TICK_HZ per second |
| blink_wr | input | 1 | Load rate and style |
| blink_rate | input | 2 | 00 off, 01 2 Hz, 10 1 Hz, 11 0.5 Hz |
| blink_alt | input | 1 | 0 blanking blink, 1 alternating blink |
| disp_wr | input | 1 | Load display switch and low-power bit |
| disp_on | input | 1 | 1 display shown, 0 blanked |
| low_pwr | input | 1 | 1 power-saving mode |
| seg_in | input | SEG_W | Segment word from the data path |
| seg_out | output | SEG_W | Gated segment word |
| blank | output | 1 | Panel dark this frame |
| bank_swap | output | 1 | Read the other memory bank |
| div_sel | output | 1 | Slow frame divider select |

## Verification
The assertions assume that `tick` is a single-cycle pulse and that the strobes are only sampled while reset is released. They also assume that `seg_in` can change in any cycle. The stimulus pulses `tick` once every three clocks, so many ticks fall on the same cycle as a write. All strobes and data change at the falling clock edge, and reset is held for several cycles before any command is issued.

// File: rtl/lcd_blink_ctl.sv
module lcd_blink_ctl #(
  parameter int SEG_W   = 8,
  parameter int TICK_HZ = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             blink_wr,
  input  logic [1:0]       blink_rate,
  input  logic             blink_alt,
  input  logic             disp_wr,
  input  logic             disp_on,
  input  logic             low_pwr,
  input  logic [SEG_W-1:0] seg_in,
  output logic [SEG_W-1:0] seg_out,
  output logic             blank,
  output logic             bank_swap,
  output logic             div_sel
);
  localparam int CNT_W = $clog2(TICK_HZ + 1);
  localparam logic [CNT_W-1:0] QTR = CNT_W'(TICK_HZ / 4);

  logic [1:0]       rate_q;
  logic             alt_q, on_q, lp_q, phase_q;
  logic [CNT_W-1:0] cnt_q, half_len;

  always_comb begin
    case (rate_q)
      2'd1:    half_len = QTR;
      2'd2:    half_len = QTR << 1;
      default: half_len = QTR << 2;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q  <= '0;
      alt_q   <= 1'b0;
      on_q    <= 1'b0;
      lp_q    <= 1'b0;
      cnt_q   <= '0;
      phase_q <= 1'b1;
    end else begin
      if (disp_wr) begin
        on_q <= disp_on;
        lp_q <= low_pwr;
      end
      if (blink_wr) begin
        rate_q  <= blink_rate;
        alt_q   <= blink_alt;
        cnt_q   <= '0;
        phase_q <= 1'b1;
      end else if (rate_q != 2'd0 && tick) begin
        if (cnt_q == half_len - CNT_W'(1)) begin
          cnt_q   <= '0;
          phase_q <= ~phase_q;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

  wire blinking = (rate_q != 2'd0) && !phase_q;

  assign blank     = !on_q || (blinking && !alt_q);
  assign seg_out   = blank ? '0 : seg_in;
  assign bank_swap = blinking && alt_q;
  assign div_sel   = lp_q;
endmodule

// File: rtl/lcd_blink_ctl_chk.sv
module lcd_blink_ctl_chk #(
  parameter int SEG_W = 8,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             blink_wr,
  input logic             disp_wr,
  input logic             low_pwr,
  input logic [SEG_W-1:0] seg_in,
  input logic [SEG_W-1:0] seg_out,
  input logic             blank,
  input logic             bank_swap,
  input logic             div_sel,
  input logic             on_q,
  input logic             phase_q,
  input logic [1:0]       rate_q,
  input logic [CNT_W-1:0] cnt_q
);
  AST_DARK_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n) !on_q |-> (blank && seg_out == '0)); // R2
  AST_IDLE_PHASE_ON: assert property (@(posedge clk) disable iff (!rst_n) (rate_q == 2'd0) |-> (phase_q && !bank_swap)); // R3
  AST_PHASE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n) (!tick && !blink_wr) |=> $stable(phase_q)); // R4
  AST_SWAP_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n) (bank_swap && on_q) |-> (seg_out == seg_in)); // R6
  AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n) blink_wr |=> (phase_q && cnt_q == '0)); // R7
  AST_LOWPWR_LOAD: assert property (@(posedge clk) disable iff (!rst_n) disp_wr |=> (div_sel == $past(low_pwr))); // R8
endmodule

bind lcd_blink_ctl lcd_blink_ctl_chk #(.SEG_W(SEG_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .blink_wr(blink_wr), .disp_wr(disp_wr),
  .low_pwr(low_pwr), .seg_in(seg_in), .seg_out(seg_out), .blank(blank),
  .bank_swap(bank_swap), .div_sel(div_sel), .on_q(on_q), .phase_q(phase_q),
  .rate_q(rate_q), .cnt_q(cnt_q)
);

// File: tb/lcd_blink_ctl_bench.sv
module lcd_blink_ctl_bench;
  localparam int SEG_W = 8;
  localparam int TICK_HZ = 8;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic blink_wr = 1'b0, blink_alt = 1'b0, disp_wr = 1'b0, disp_on = 1'b0, low_pwr = 1'b0;
  logic [1:0] blink_rate = 2'd0;
  logic [SEG_W-1:0] seg_in = '0, seg_out;
  logic blank, bank_swap, div_sel;

  int checks = 0, failures = 0;
  bit done = 0;

  int m_rate = 0, m_alt = 0, m_on = 0, m_lp = 0, m_cnt = 0, m_vis = 1;

  always #5 clk = ~clk;

  lcd_blink_ctl #(.SEG_W(SEG_W), .TICK_HZ(TICK_HZ)) u_lcd_blink_ctl (
    .clk(clk), .rst_n(rst_n), .tick(tick), .blink_wr(blink_wr), .blink_rate(blink_rate),
    .blink_alt(blink_alt), .disp_wr(disp_wr), .disp_on(disp_on), .low_pwr(low_pwr),
    .seg_in(seg_in), .seg_out(seg_out), .blank(blank), .bank_swap(bank_swap), .div_sel(div_sel)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // R4: half period in ticks for each rate code
  function automatic int half_ticks(input int code);
    return (TICK_HZ / 4) * (1 << (code - 1));
  endfunction

  task automatic model_step();
    if (!rst_n) begin
      m_rate = 0; m_alt = 0; m_on = 0; m_lp = 0; m_cnt = 0; m_vis = 1;
      return;
    end
    if (disp_wr) begin m_on = disp_on; m_lp = low_pwr; end
    if (blink_wr) begin
      m_rate = blink_rate; m_alt = blink_alt; m_cnt = 0; m_vis = 1;
    end else if (m_rate != 0 && tick) begin
      m_cnt++;
      if (m_cnt >= half_ticks(m_rate)) begin m_cnt = 0; m_vis = !m_vis; end
    end
  endtask

  task automatic compare();
    int second_half = (m_rate != 0) && !m_vis;
    int exp_blank = !m_on || (second_half && !m_alt);
    int exp_seg = exp_blank ? 0 : int'(seg_in);
    string tag;
    if (!m_on) tag = "R2";
    else if (m_rate == 0) tag = "R3";
    else if (m_alt) tag = "R6";
    else tag = "R5";
    chk({tag, " blank"}, blank, exp_blank);
    chk({tag, " seg_out"}, seg_out, exp_seg);
    chk({tag, "/R7 bank_swap"}, bank_swap, second_half && m_alt);
    chk("R8 div_sel", div_sel, m_lp);
  endtask

  task automatic drive(input int c);
    tick = (c % 3 == 0);
    seg_in = SEG_W'($urandom);
    blink_wr = 1'b0; disp_wr = 1'b0;
    case (c)
      2:    begin disp_wr = 1; disp_on = 1; low_pwr = 0; end
      4:    begin blink_wr = 1; blink_rate = 2'd1; blink_alt = 0; end
      100:  begin blink_wr = 1; blink_rate = 2'd2; blink_alt = 0; end
      250:  begin blink_wr = 1; blink_rate = 2'd3; blink_alt = 1; end
      300:  begin disp_wr = 1; disp_on = 1; low_pwr = 1; end  // R9 blink state unaffected
      500:  begin disp_wr = 1; disp_on = 0; low_pwr = 1; end
      560:  begin disp_wr = 1; disp_on = 1; low_pwr = 0; end
      600:  begin blink_wr = 1; blink_rate = 2'd0; blink_alt = 1; end
      680:  begin blink_wr = 1; blink_rate = 2'd1; blink_alt = 1; end
      690:  begin blink_wr = 1; blink_rate = 2'd1; blink_alt = 1; end
      700:  begin blink_wr = 1; blink_rate = 2'd2; blink_alt = 0; end  // R9 display bits unaffected
      800:  begin blink_wr = 1; blink_rate = 2'd3; blink_alt = 0; end
      900:  begin disp_wr = 1; disp_on = 0; low_pwr = 0; end
      950:  begin disp_wr = 1; disp_on = 1; low_pwr = 1; end
      default: ;
    endcase
  endtask

  initial begin
    repeat (4) begin
      @(negedge clk);
      model_step();
      compare();
    end
    chk("R1 reset blank", blank, 1);
    chk("R1 reset seg_out", seg_out, 0);
    chk("R1 reset bank_swap", bank_swap, 0);
    chk("R1 reset div_sel", div_sel, 0);
    rst_n = 1'b1;
    for (int c = 0; c < 1100; c++) begin
      drive(c);
      @(negedge clk);
      model_step();
      compare();
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule